// File: doc/BRIEF.md
# Dual-Accumulator Fractional Multiply-Accumulate Engine

This engine is the arithmetic core of a 16-bit signal-processing datapath. It takes two 16-bit operands and extends each to 17 bits, as signed or unsigned values. It multiplies them and then loads, adds or subtracts the product into one of two 40-bit accumulators, A or B. It can also combine the two accumulators or negate one of them without any new operand. After each accepted operation it presents a 16-bit write-back word. That word is the updated target accumulator, rounded to bits [31:16] and optionally clamped to the 16-bit range.

Operations arrive on a valid/ready stream, and each result leaves on a second valid/ready stream. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. The result word appears on the next cycle and stays stable while `out_valid` is high and `out_ready` is low. `in_ready` is low only while an unconsumed result is stalled. This back-pressure reaches the producer within the same cycle.

Mode and saturation settings are plain level inputs, sampled at the accepting edge. The accumulators and their flags are visible on plain status outputs.

Top module: `mac_engine`

## Requirements
- R1: `in_tgt` selects the target accumulator: 0 = A, 1 = B. `in_op` codes are:
  - 0: clear the target.
  - 1: target + product.
  - 2: target − product.
  - 3: load the product.
  - 4: load the negated product.
  
  With `cfg_unsigned`=0 the operands are sign-extended to 17 bits; with `cfg_unsigned`=1 they are zero-extended.
- R2: With `cfg_frac`=1 the 17x17 product is doubled (shifted left one bit) before use. With `cfg_frac`=0 it is used as is.
- R3: When the target's enable (`cfg_sat_a` or `cfg_sat_b`) is 1 and `cfg_super`=0, the stored result is clamped to [-2^31, 2^31-1].
- R4: When the target's enable is 1 and `cfg_super`=1, the stored result is clamped to [-2^39, 2^39-1]. When the enable is 0, the result wraps modulo 2^40.
- R5: `in_op` 5 stores target + other accumulator, 6 stores target − other, and 7 stores −target. The operands are ignored for these codes.
- R6: The write-back word is the target's bits [31:16] after rounding on bits [15:0].
  - With `cfg_convergent`=0, it rounds up when bits [15:0] ≥ 0x8000.
  - With `cfg_convergent`=1, it rounds up above 0x8000. At exactly 0x8000 it rounds up only if bit 16 is 1.
- R7: With `cfg_sat_wb`=1, a rounded value above 0x7FFF gives 0x7FFF and one below −0x8000 gives 0x8000. With `cfg_sat_wb`=0, the low 16 bits are passed through.
- R8: `ovf_a`/`ovf_b` are high exactly while the accumulator holds a value outside [-2^31, 2^31-1].
- R9: `sat_a`/`sat_b` set when a clamp occurs on that accumulator. They stay set until a cycle with `clr_sticky`=1 and no new clamp on that accumulator; a clamp in the same cycle wins.
- R10: `in_ready` = !`out_valid` || `out_ready`. While stalled, `out_word` holds and no operation is taken, so the accumulators do not change.
- R11: After reset, both accumulators are 0, all flags are 0, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_frac | input | 1 | 1 = fractional product (doubled) |
| cfg_unsigned | input | 1 | 1 = zero-extend operands |
| cfg_convergent | input | 1 | 1 = round half to even |
| cfg_sat_a | input | 1 | Saturation enable for accumulator A |
| cfg_sat_b | input | 1 | Saturation enable for accumulator B |
| cfg_sat_wb | input | 1 | Saturation enable for the write-back word |
| cfg_super | input | 1 | 1 = 40-bit clamp limits, 0 = 32-bit limits |
| clr_sticky | input | 1 | Clears the sticky saturation flags |
| in_valid | input | 1 | Operation valid |
| in_ready | output | 1 | Engine can take an operation |
| in_op | input | 3 | Operation code |
| in_tgt | input | 1 | Target accumulator, 0 = A, 1 = B |
| in_x | input | 16 | First operand |
| in_y | input | 16 | Second operand |
| out_valid | output | 1 | Write-back word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 16 | Rounded write-back word |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | A outside 32-bit range |
| ovf_b | output | 1 | B outside 32-bit range |
| sat_a | output | 1 | Sticky clamp flag for A |
| sat_b | output | 1 | Sticky clamp flag for B |

## Verification
The assertions assume that the configuration inputs and the operation fields are stable around each accepting edge, because they are sampled only there. The stimulus changes every input at the falling edge, so each accepting edge sees settled values. The consumer side is also assumed to hold `out_ready` steady within a cycle. The stall check depends on this: it raises `out_ready` only at a falling edge, after observing `in_ready` low for a full cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int DATA_W = 16;
  localparam int ACC_W  = 40;
  localparam int NORM_W = 32;

  typedef enum logic [2:0] {
    OP_ZERO     = 3'd0,
    OP_ADD_PROD = 3'd1,
    OP_SUB_PROD = 3'd2,
    OP_LOAD     = 3'd3,
    OP_LOAD_NEG = 3'd4,
    OP_SUM      = 3'd5,
    OP_DIFF     = 3'd6,
    OP_NEGATE   = 3'd7
  } op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic [DW-1:0]        x_i,
  input  logic [DW-1:0]        y_i,
  input  logic                 uns_i,
  input  logic                 frac_i,
  output logic signed [AW-1:0] prod_o
);
  localparam int EW = DW + 1;
  localparam int PW = 2 * EW;

  logic signed [EW-1:0] xe, ye;
  logic signed [PW-1:0] p;
  logic signed [AW-1:0] full;

  always_comb begin
    // R1: extension bit follows the signed/unsigned selection
    xe = {~uns_i & x_i[DW-1], x_i};
    ye = {~uns_i & y_i[DW-1], y_i};
    p = xe * ye;
    full = {{(AW-PW){p[PW-1]}}, p};
    // R2: fractional mode doubles the product
    prod_o = frac_i ? (full <<< 1) : full;
  end
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
  parameter int AW = 40,
  parameter int NW = 32
) (
  input  logic signed [AW:0]   raw_i,
  input  logic                 en_i,
  input  logic                 super_i,
  output logic signed [AW-1:0] val_o,
  output logic                 clamped_o
);
  logic out_norm, out_super, hit;

  always_comb begin
    out_norm  = !((&raw_i[AW:NW-1]) || !(|raw_i[AW:NW-1]));
    out_super = raw_i[AW] ^ raw_i[AW-1];
    hit = en_i && (super_i ? out_super : out_norm);
    clamped_o = hit;
    if (!hit)
      val_o = raw_i[AW-1:0];                 // R4: wrap modulo 2^AW
    else if (super_i)
      val_o = raw_i[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
    else
      val_o = raw_i[AW] ? {{(AW-NW+1){1'b1}}, {(NW-1){1'b0}}}
                        : {{(AW-NW+1){1'b0}}, {(NW-1){1'b1}}};
  end
endmodule

// File: rtl/mac_round.sv
module mac_round #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic [AW-1:0] acc_i,
  input  logic          conv_i,
  input  logic          wbsat_i,
  output logic [DW-1:0] word_o
);
  localparam int RW = AW - DW + 1;

  logic [DW-1:0] low;
  logic          half, up, ovr;
  logic [RW-1:0] r;

  always_comb begin
    low  = acc_i[DW-1:0];
    half = (low == {1'b1, {(DW-1){1'b0}}});
    // R6: ties go up (conventional) or to even (convergent)
    up   = conv_i ? (low[DW-1] && (!half || acc_i[DW])) : low[DW-1];
    r    = {acc_i[AW-1], acc_i[AW-1:DW]} + RW'(up);
    ovr  = !((&r[RW-1:DW-1]) || !(|r[RW-1:DW-1]));
    // R7: optional clamp of the write-back word
    if (wbsat_i && ovr)
      word_o = r[RW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else
      word_o = r[DW-1:0];
  end
endmodule

// File: rtl/mac_engine.sv
module mac_engine
  import mac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ACC_W,
  parameter int NW = NORM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_frac,
  input  logic          cfg_unsigned,
  input  logic          cfg_convergent,
  input  logic          cfg_sat_a,
  input  logic          cfg_sat_b,
  input  logic          cfg_sat_wb,
  input  logic          cfg_super,
  input  logic          clr_sticky,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic          in_tgt,
  input  logic [DW-1:0] in_x,
  input  logic [DW-1:0] in_y,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_word,
  output logic [AW-1:0] acc_a,
  output logic [AW-1:0] acc_b,
  output logic          ovf_a,
  output logic          ovf_b,
  output logic          sat_a,
  output logic          sat_b
);
  localparam int NACC = 2;

  op_e                  op;
  logic                 fire;
  logic signed [AW-1:0] prod, cur, oth, res;
  logic signed [AW-1:0] acc_q [NACC];
  logic signed [AW:0]   raw;
  logic [NACC-1:0]      sat_en, ovf_q, stk_q;
  logic                 clamped;
  logic [DW-1:0]        word;

  assign op       = op_e'(in_op);
  assign in_ready = !out_valid || out_ready;   // R10
  assign fire     = in_valid && in_ready;
  assign sat_en   = {cfg_sat_b, cfg_sat_a};

  mac_mult #(.DW(DW), .AW(AW)) u_mult (
    .x_i(in_x), .y_i(in_y), .uns_i(cfg_unsigned), .frac_i(cfg_frac), .prod_o(prod)
  );

  always_comb begin
    cur = acc_q[in_tgt];
    oth = acc_q[~in_tgt];
    case (op)
      OP_ZERO:     raw = '0;
      OP_ADD_PROD: raw = {cur[AW-1], cur} + {prod[AW-1], prod};
      OP_SUB_PROD: raw = {cur[AW-1], cur} - {prod[AW-1], prod};
      OP_LOAD:     raw = {prod[AW-1], prod};
      OP_LOAD_NEG: raw = '0 - {prod[AW-1], prod};
      OP_SUM:      raw = {cur[AW-1], cur} + {oth[AW-1], oth};   // R5
      OP_DIFF:     raw = {cur[AW-1], cur} - {oth[AW-1], oth};
      OP_NEGATE:   raw = '0 - {cur[AW-1], cur};
      default:     raw = '0;
    endcase
  end

  mac_sat #(.AW(AW), .NW(NW)) u_sat (
    .raw_i(raw), .en_i(sat_en[in_tgt]), .super_i(cfg_super),
    .val_o(res), .clamped_o(clamped)
  );

  mac_round #(.DW(DW), .AW(AW)) u_round (
    .acc_i(res), .conv_i(cfg_convergent), .wbsat_i(cfg_sat_wb), .word_o(word)
  );

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    logic signed [AW-1:0] acc_r;
    logic                 ovf_r, stk_r;
    logic                 hit;
    assign hit = fire && (in_tgt == 1'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_r <= '0;
        ovf_r <= 1'b0;
        stk_r <= 1'b0;
      end else begin
        if (hit) begin
          acc_r <= res;
          ovf_r <= !((&res[AW-1:NW-1]) || !(|res[AW-1:NW-1]));   // R8
        end
        if (hit && clamped) stk_r <= 1'b1;                        // R9
        else if (clr_sticky) stk_r <= 1'b0;
      end
    end
    assign acc_q[g] = acc_r;
    assign ovf_q[g] = ovf_r;
    assign stk_q[g] = stk_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_word  <= word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign acc_a = acc_q[0];
  assign acc_b = acc_q[1];
  assign ovf_a = ovf_q[0];
  assign ovf_b = ovf_q[1];
  assign sat_a = stk_q[0];
  assign sat_b = stk_q[1];

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  p_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> $stable(acc_a) && $stable(acc_b));

  p_norm_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_tgt && cfg_sat_a && !cfg_super |=> !ovf_a);

  p_sticky_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sat_a && !clr_sticky |=> sat_a);

  p_zero_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_tgt && (in_op == 3'd0) |=> acc_b == '0);
endmodule

// File: tb/mac_engine_bench.sv
module mac_engine_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst_n;
  logic cfg_frac, cfg_unsigned, cfg_convergent, cfg_sat_a, cfg_sat_b, cfg_sat_wb, cfg_super;
  logic clr_sticky, in_valid, in_ready, in_tgt, out_valid, out_ready;
  logic [2:0]  in_op;
  logic [15:0] in_x, in_y, out_word;
  logic [39:0] acc_a, acc_b;
  logic ovf_a, ovf_b, sat_a, sat_b;

  mac_engine u_mac_engine (
    .clk(clk), .rst_n(rst_n), .cfg_frac(cfg_frac), .cfg_unsigned(cfg_unsigned),
    .cfg_convergent(cfg_convergent), .cfg_sat_a(cfg_sat_a), .cfg_sat_b(cfg_sat_b),
    .cfg_sat_wb(cfg_sat_wb), .cfg_super(cfg_super), .clr_sticky(clr_sticky),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_tgt(in_tgt),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a), .ovf_b(ovf_b),
    .sat_a(sat_a), .sat_b(sat_b)
  );

  // {frac, unsigned, convergent, sat_a, sat_b, sat_wb, super}, op, tgt, x, y
  localparam logic [42:0] VEC [16] = '{
    {7'b0000000, 3'd3, 1'b0, 16'h1234, 16'h0010},
    {7'b0000000, 3'd1, 1'b0, 16'hFFFF, 16'h0100},
    {7'b0000000, 3'd2, 1'b1, 16'h7FFF, 16'h7FFF},
    {7'b1000000, 3'd1, 1'b0, 16'h4000, 16'h4000},
    {7'b0100000, 3'd3, 1'b1, 16'hFFFF, 16'hFFFF},
    {7'b1100000, 3'd1, 1'b1, 16'hFFFF, 16'hFFFF},
    {7'b0000000, 3'd5, 1'b0, 16'h0000, 16'h0000},
    {7'b0000000, 3'd6, 1'b1, 16'h5555, 16'hAAAA},
    {7'b0000000, 3'd7, 1'b0, 16'h0000, 16'h0000},
    {7'b0010000, 3'd4, 1'b0, 16'h0123, 16'h0456},
    {7'b1011110, 3'd1, 1'b0, 16'h8000, 16'h8000},
    {7'b1011111, 3'd1, 1'b1, 16'h8000, 16'h8000},
    {7'b0001000, 3'd0, 1'b0, 16'h1111, 16'h2222},
    {7'b0000000, 3'd2, 1'b0, 16'h8000, 16'h7FFF},
    {7'b0010010, 3'd3, 1'b1, 16'h0003, 16'h8000},
    {7'b0000000, 3'd5, 1'b1, 16'h0000, 16'h0000}
  };

  int checks = 0, fails = 0;
  longint ma = 0, mb = 0;
  bit ms_a = 0, ms_b = 0, mo_a = 0, mo_b = 0;
  logic [15:0] exp_word = '0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic longint wrap40(input longint v);
    return (v <<< 24) >>> 24;
  endfunction

  function automatic longint sx40(input logic [39:0] v);
    return wrap40(longint'({24'h0, v}));
  endfunction

  // Reference model from the requirements, 64-bit integer arithmetic
  task automatic model_step(input logic [6:0] c, input logic [2:0] op, input logic t,
                            input logic [15:0] x, input logic [15:0] y, input logic clr);
    longint xs, ys, p, cur, oth, raw, lim, r, low;
    bit en, clamp, inc;
    xs = c[5] ? longint'({48'h0, x}) : longint'($signed(x));
    ys = c[5] ? longint'({48'h0, y}) : longint'($signed(y));
    p = xs * ys;
    if (c[6]) p = p * 2;
    cur = t ? mb : ma;
    oth = t ? ma : mb;
    case (op)
      3'd0: raw = 0;
      3'd1: raw = cur + p;
      3'd2: raw = cur - p;
      3'd3: raw = p;
      3'd4: raw = -p;
      3'd5: raw = cur + oth;
      3'd6: raw = cur - oth;
      default: raw = -cur;
    endcase
    en = t ? c[2] : c[3];
    lim = c[0] ? (64'sd1 <<< 39) : (64'sd1 <<< 31);
    clamp = 0;
    if (en && raw > lim - 1) begin raw = lim - 1; clamp = 1; end
    else if (en && raw < -lim) begin raw = -lim; clamp = 1; end
    raw = wrap40(raw);
    low = raw & 64'hFFFF;
    inc = c[4] ? ((low > 64'h8000) || (low == 64'h8000 && raw[16])) : (low >= 64'h8000);
    r = (raw >>> 16) + longint'(inc);
    if (c[1] && r > 32767) r = 32767;
    if (c[1] && r < -32768) r = -32768;
    exp_word = r[15:0];
    if (t) begin
      mb = raw; mo_b = (raw > 64'sh7FFFFFFF) || (raw < -(64'sd1 <<< 31));
    end else begin
      ma = raw; mo_a = (raw > 64'sh7FFFFFFF) || (raw < -(64'sd1 <<< 31));
    end
    if (!t && clamp) ms_a = 1; else if (clr) ms_a = 0;
    if (t && clamp) ms_b = 1; else if (clr) ms_b = 0;
  endtask

  task automatic check_state(input string tag);
    chk(tag, "acc_a", sx40(acc_a), ma);
    chk(tag, "acc_b", sx40(acc_b), mb);
    chk(tag, "out_word", longint'(out_word), longint'(exp_word));
    chk(tag, "flags ovf_a,ovf_b,sat_a,sat_b", longint'({ovf_a, ovf_b, sat_a, sat_b}),
        longint'({mo_a, mo_b, ms_a, ms_b}));
    chk(tag, "out_valid", longint'(out_valid), 1);
  endtask

  task automatic set_cfg(input logic [6:0] c);
    {cfg_frac, cfg_unsigned, cfg_convergent, cfg_sat_a, cfg_sat_b, cfg_sat_wb, cfg_super} = c;
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance
  task automatic run_op(input logic [6:0] c, input logic [2:0] op, input logic t,
                        input logic [15:0] x, input logic [15:0] y, input logic clr,
                        input string tag);
    set_cfg(c);
    in_op = op; in_tgt = t; in_x = x; in_y = y; clr_sticky = clr;
    in_valid = 1'b1; out_ready = 1'b1;
    model_step(c, op, t, x, y, clr);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; clr_sticky = 1'b0;
    check_state(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; set_cfg(7'b0); clr_sticky = 0; in_valid = 0; in_op = 0; in_tgt = 0;
    in_x = 0; in_y = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "acc_a", longint'(acc_a), 0);
    chk("R11", "acc_b", longint'(acc_b), 0);
    chk("R11", "flags", longint'({ovf_a, ovf_b, sat_a, sat_b}), 0);
    chk("R11", "out_valid/in_ready", longint'({out_valid, in_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: table of mixed modes and operations
    for (int i = 0; i < 16; i++)
      run_op(VEC[i][42:36], VEC[i][35:33], VEC[i][32], VEC[i][31:16], VEC[i][15:0], 1'b0, "R1");

    // R2: fractional versus integer product
    run_op(7'b1000000, 3'd3, 1'b0, 16'h4000, 16'h4000, 0, "R2");
    chk("R2", "frac product", longint'(acc_a), 64'h20000000);
    run_op(7'b0000000, 3'd3, 1'b0, 16'h4000, 16'h4000, 0, "R2");
    chk("R2", "int product", longint'(acc_a), 64'h10000000);

    // R5: accumulator-to-accumulator operations
    run_op(7'b0, 3'd3, 1'b0, 16'd2, 16'd3, 0, "R5");
    run_op(7'b0, 3'd3, 1'b1, 16'd10, 16'd1, 0, "R5");
    run_op(7'b0, 3'd6, 1'b0, 16'hFFFF, 16'hFFFF, 0, "R5");
    chk("R5", "A-B", longint'(acc_a), 64'hFF_FFFF_FFFC);
    run_op(7'b0, 3'd7, 1'b1, 16'h1234, 16'h1234, 0, "R5");
    chk("R5", "-B", longint'(acc_b), 64'hFF_FFFF_FFF6);

    // R6: rounding of ties
    run_op(7'b0100000, 3'd3, 1'b0, 16'd1, 16'h8000, 0, "R6");
    chk("R6", "conventional tie", longint'(out_word), 1);
    run_op(7'b0110000, 3'd3, 1'b0, 16'd1, 16'h8000, 0, "R6");
    chk("R6", "convergent tie even", longint'(out_word), 0);
    run_op(7'b0110000, 3'd3, 1'b0, 16'd3, 16'h8000, 0, "R6");
    chk("R6", "convergent tie odd", longint'(out_word), 2);

    // R8: overflow flag without saturation
    run_op(7'b1000000, 3'd3, 1'b0, 16'h8000, 16'h8000, 0, "R8");
    chk("R8", "ovf_a", longint'(ovf_a), 1);
    chk("R8", "acc_a", longint'(acc_a), 64'h80000000);

    // R3 and R7: normal clamp and write-back clamp
    run_op(7'b1001010, 3'd3, 1'b0, 16'h8000, 16'h8000, 0, "R3");
    chk("R3", "acc_a clamp", longint'(acc_a), 64'h7FFFFFFF);
    chk("R7", "wb clamp", longint'(out_word), 64'h7FFF);
    run_op(7'b1001000, 3'd3, 1'b0, 16'h8000, 16'h8000, 0, "R7");
    chk("R7", "wb pass", longint'(out_word), 64'h8000);

    // R9: sticky flag clear and set-wins
    @(negedge clk);
    clr_sticky = 1'b1;
    @(posedge clk); @(negedge clk);
    clr_sticky = 1'b0; ms_a = 0;
    chk("R9", "sat_a cleared", longint'(sat_a), 0);
    run_op(7'b1001000, 3'd3, 1'b0, 16'h8000, 16'h8000, 1, "R9");
    chk("R9", "set wins over clear", longint'(sat_a), 1);

    // R4: super saturation then wrap
    run_op(7'b0, 3'd0, 1'b0, 16'h0, 16'h0, 0, "R4");
    for (int k = 0; k < 70; k++)
      run_op(7'b1101001, 3'd1, 1'b0, 16'hFFFF, 16'hFFFF, 0, "R4");
    chk("R4", "super clamp", longint'(acc_a), 64'h7F_FFFF_FFFF);
    run_op(7'b1100000, 3'd1, 1'b0, 16'hFFFF, 16'hFFFF, 0, "R4");

    // R10: back-pressure
    @(negedge clk);
    set_cfg(7'b0); in_op = 3'd3; in_tgt = 0; in_x = 16'd5; in_y = 16'h0100;
    out_ready = 1'b0; in_valid = 1'b1;
    model_step(7'b0, 3'd3, 1'b0, 16'd5, 16'h0100, 0);
    held = exp_word;
    @(posedge clk); @(negedge clk);
    chk("R10", "first word", longint'({out_valid, out_word}), longint'({1'b1, held}));
    in_op = 3'd1; in_x = 16'd1; in_y = 16'd1;
    #1 chk("R10", "in_ready low", longint'(in_ready), 0);
    @(posedge clk); @(negedge clk);
    chk("R10", "acc held", sx40(acc_a), ma);
    chk("R10", "word held", longint'(out_word), longint'(held));
    out_ready = 1'b1;
    #1 chk("R10", "in_ready high", longint'(in_ready), 1);
    model_step(7'b0, 3'd1, 1'b0, 16'd1, 16'd1, 0);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check_state("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule